// File: doc/BRIEF.md
# DMA Channel Control/Status Registers with Completion Interrupt Coalescing

This block holds the software-visible registers of a single DMA channel and gathers completion events into fewer interrupts. A 32-bit register port lets software read and write four registers: control, status, current-descriptor pointer and tail-descriptor pointer. The data engine driven by this slice receives run, soft-reset, halted and idle levels, plus a one-cycle start strobe whenever software moves the tail pointer. The engine returns a one-cycle completion pulse per finished packet and a pulse when it has run out of work.

Two mechanisms coalesce interrupts. A countdown counter loaded from a threshold field raises a completion interrupt every N completions. A delay timer restarts on every completion, counts down on an external tick enable, and raises a separate delay interrupt when it runs out. That way a trickle of traffic below the threshold still gets serviced. Both live counts can be read in the upper half of the status register. The interrupt output is a level: it is the OR of the pending bits gated by per-bit enables in the control register.

Top module: `dma_chan_csr`

## Requirements
- R1: After reset, control reads 0x0001_0002 (threshold 1, tail-mode bit set). Status reads 0x0001_0001 (count 1, halted). Both descriptor pointers read 0 and the interrupt is low.
- R2: Register byte offsets are: control 0x00, status 0x04, current descriptor 0x08, tail descriptor 0x10. Control bit 0 is run, bit 2 is soft reset, bits 13:12 enable the two interrupts, bits 23:16 hold the threshold and bits 31:24 hold the delay. Control bit 1 reads as 1 whatever was written.
- R3: A control write with bit 0 set and bit 2 clear, while no soft reset is pending, clears halted (status bit 0) and idle (status bit 1) in the next cycle. eng_run follows control bit 0.
- R4: A control write with bit 2 set does the following: it makes control 0x0001_0000 plus the pending reset bit, sets halted, clears idle and both interrupt bits, zeroes the timer and loads the count with 1. The reset bit stays set, including through later control writes, which cannot start the channel. It clears after the first control read, and that read still returns it as 1.
- R5: Each completion pulse decrements the count. When the count reaches zero, status bit 12 sets and the count reloads from control bits 23:16. Any control write reloads the count from the written threshold. A control write beats a completion in the same cycle.
- R6: A completion with a nonzero delay field loads the timer with that field. A completion with a zero delay field leaves the timer alone. On each tick, a nonzero timer decrements. When it reaches zero, status bit 13 sets and the count reloads from the threshold, unless a completion decrements the count in that same cycle.
- R7: Writing status with ones in bits 13:12 clears those pending bits. Zeros leave them alone. A bit set and cleared in the same cycle ends up set.
- R8: irq is high exactly when some status bit among 13:12 and the same control bit are both 1.
- R9: A status read returns the timer in bits 31:24, the count in bits 23:16, pending bits in 13:12, idle in bit 1 and halted in bit 0. All other bits read 0.
- R10: A tail write stores the pointer, clears idle, and pulses eng_start for one cycle in the next cycle. An idle_req pulse sets idle, except when a tail write or a run start in the same cycle clears it.
- R11: The current-descriptor register is read/write. Reads of other offsets return 0. Writes to other offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte offset inside the channel window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle reg_rd_en is high |
| cmpl_pulse | input | 1 | One-cycle completion event from the engine |
| tmr_tick | input | 1 | Clock enable for the delay timer |
| idle_req | input | 1 | Engine pulse: descriptor chain exhausted |
| irq | output | 1 | Level interrupt |
| eng_run | output | 1 | Run level to the engine |
| eng_reset | output | 1 | Soft reset pending |
| eng_halted | output | 1 | Channel halted |
| eng_idle | output | 1 | Channel idle |
| eng_start | output | 1 | One-cycle start strobe after a tail write |
| cur_desc | output | 32 | Current-descriptor pointer |
| tail_desc | output | 32 | Tail-descriptor pointer |

## Verification
Coalescing is driven in four ways. A steady completion stream with the delay off shows whether the threshold counter alone raises the completion interrupt at the right count. Isolated completions with the delay on and sparse ticks separate a timer expiry from a threshold hit. Completions landing on the tick that would expire the timer show whether the restart takes priority. A long pseudo-random mix of completions, ticks, clears and status reads runs against the reference model, and it exposes ordering errors between a set and a clear in the same cycle. Soft reset is tried both alone and followed by a run write, to tell a sticky pending reset from one that a later write silently drops.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;
  // word indices inside the channel window (byte offset / 4)
  localparam int unsigned WORD_CTRL = 0;
  localparam int unsigned WORD_STAT = 1;
  localparam int unsigned WORD_CUR  = 2;
  localparam int unsigned WORD_TAIL = 4;

  // control fields
  localparam int unsigned RUN_BIT   = 0;
  localparam int unsigned TMODE_BIT = 1;
  localparam int unsigned SRST_BIT  = 2;

  // interrupt field, shared position in control (enable) and status (pending)
  localparam int unsigned IRQ_LO = 12;
  localparam int unsigned IRQ_N  = 2;
  localparam int unsigned IRQ_IOC = 0;
  localparam int unsigned IRQ_DLY = 1;

  // coalescing fields, shared position in control (setting) and status (live)
  localparam int unsigned CNT_LO = 16;
  localparam int unsigned CNT_W  = 8;
  localparam int unsigned TMR_LO = 24;
  localparam int unsigned TMR_W  = 8;

  localparam logic [CNT_W-1:0] CNT_RST = CNT_W'(1);

  typedef struct packed {
    logic wr_ctrl;
    logic wr_stat;
    logic wr_cur;
    logic wr_tail;
    logic rd_ctrl;
  } csr_strb_t;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_STAT,
    SEL_CUR,
    SEL_TAIL
  } rd_sel_t;
endpackage

// File: rtl/dma_csr_decode.sv
module dma_csr_decode
  import dma_csr_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  output csr_strb_t         strb,
  output rd_sel_t           rd_sel
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  assign word = addr[ADDR_W-1:2];

  always_comb begin
    strb   = '0;
    rd_sel = SEL_NONE;
    if (word == WORD_W'(WORD_CTRL)) begin
      strb.wr_ctrl = wr_en;
      strb.rd_ctrl = rd_en;
      if (rd_en) rd_sel = SEL_CTRL;
    end else if (word == WORD_W'(WORD_STAT)) begin
      strb.wr_stat = wr_en;
      if (rd_en) rd_sel = SEL_STAT;
    end else if (word == WORD_W'(WORD_CUR)) begin
      strb.wr_cur = wr_en;
      if (rd_en) rd_sel = SEL_CUR;
    end else if (word == WORD_W'(WORD_TAIL)) begin
      strb.wr_tail = wr_en;
      if (rd_en) rd_sel = SEL_TAIL;
    end
  end
endmodule

// File: rtl/dma_cmpl_counter.sv
module dma_cmpl_counter #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_VAL = W'(1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  input  logic         reload,
  input  logic [W-1:0] thr,
  output logic [W-1:0] cnt,
  output logic         hit
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    hit   = dec && (cnt_q == W'(1));
    cnt_d = cnt_q;
    if (load)        cnt_d = load_val;
    else if (dec)    cnt_d = hit ? thr : cnt_q - W'(1);
    else if (reload) cnt_d = thr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= RST_VAL;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/dma_delay_timer.sv
module dma_delay_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         restart,
  input  logic [W-1:0] delay,
  input  logic         tick,
  output logic [W-1:0] tmr,
  output logic         expire
);
  logic [W-1:0] tmr_q, tmr_d;
  logic         restart_eff;

  always_comb begin
    restart_eff = restart && (delay != '0);
    expire      = !restart_eff && tick && (tmr_q == W'(1));
    tmr_d       = tmr_q;
    if (clear)                       tmr_d = '0;
    else if (restart_eff)            tmr_d = delay;
    else if (tick && tmr_q != '0)    tmr_d = tmr_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_q <= '0;
    else        tmr_q <= tmr_d;
  end

  assign tmr = tmr_q;
endmodule

// File: rtl/dma_chan_csr.sv
module dma_chan_csr
  import dma_csr_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              cmpl_pulse,
  input  logic              tmr_tick,
  input  logic              idle_req,
  output logic              irq,
  output logic              eng_run,
  output logic              eng_reset,
  output logic              eng_halted,
  output logic              eng_idle,
  output logic              eng_start,
  output logic [31:0]       cur_desc,
  output logic [31:0]       tail_desc
);
  localparam logic [31:0] CTRL_RST = 32'(CNT_RST) << CNT_LO;

  csr_strb_t strb;
  rd_sel_t   rd_sel;

  logic [31:0]      ctrl_q, ctrl_d;
  logic             srst_q, srst_d;
  logic             halted_q, halted_d;
  logic             idle_q, idle_d;
  logic [IRQ_N-1:0] pend_q, pend_d;
  logic [31:0]      cur_q, cur_d;
  logic [31:0]      tail_q, tail_d;
  logic             start_q, start_d;

  logic             soft_rst;
  logic             run_start;
  logic             cnt_load;
  logic [CNT_W-1:0] cnt_load_val;
  logic [CNT_W-1:0] cnt_val;
  logic [TMR_W-1:0] tmr_val;
  logic             ioc_hit;
  logic             dly_exp;
  logic [IRQ_N-1:0] pend_clr;
  logic [IRQ_N-1:0] pend_set;

  dma_csr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en  (reg_wr_en),
    .rd_en  (reg_rd_en),
    .addr   (reg_addr),
    .strb   (strb),
    .rd_sel (rd_sel)
  );

  // control-side events
  assign soft_rst  = strb.wr_ctrl && reg_wdata[SRST_BIT];
  assign run_start = strb.wr_ctrl && !soft_rst && reg_wdata[RUN_BIT] && !srst_q;

  assign cnt_load     = strb.wr_ctrl;
  assign cnt_load_val = soft_rst ? CNT_RST : reg_wdata[CNT_LO +: CNT_W];

  dma_cmpl_counter #(.W(CNT_W), .RST_VAL(CNT_RST)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (cnt_load_val),
    .dec      (cmpl_pulse),
    .reload   (dly_exp),
    .thr      (ctrl_q[CNT_LO +: CNT_W]),
    .cnt      (cnt_val),
    .hit      (ioc_hit)
  );

  dma_delay_timer #(.W(TMR_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (soft_rst),
    .restart (cmpl_pulse),
    .delay   (ctrl_q[TMR_LO +: TMR_W]),
    .tick    (tmr_tick),
    .tmr     (tmr_val),
    .expire  (dly_exp)
  );

  // pending interrupt sources, one bit per coalescing mechanism
  always_comb begin
    pend_set          = '0;
    pend_set[IRQ_IOC] = ioc_hit;
    pend_set[IRQ_DLY] = dly_exp;
    pend_clr          = strb.wr_stat ? reg_wdata[IRQ_LO +: IRQ_N] : '0;
  end

  // next-state
  always_comb begin
    ctrl_d   = ctrl_q;
    srst_d   = srst_q;
    halted_d = halted_q;
    idle_d   = idle_q;
    pend_d   = (pend_q & ~pend_clr) | pend_set;
    cur_d    = cur_q;
    tail_d   = tail_q;
    start_d  = strb.wr_tail;

    if (idle_req) idle_d = 1'b1;

    if (soft_rst) begin
      ctrl_d   = CTRL_RST;
      srst_d   = 1'b1;
      halted_d = 1'b1;
      idle_d   = 1'b0;
      pend_d   = '0;
    end else if (strb.wr_ctrl) begin
      ctrl_d            = reg_wdata;
      ctrl_d[TMODE_BIT] = 1'b0;
      ctrl_d[SRST_BIT]  = 1'b0;
    end else if (strb.rd_ctrl) begin
      srst_d = 1'b0;
    end

    if (run_start) begin
      halted_d = 1'b0;
      idle_d   = 1'b0;
    end

    if (strb.wr_cur) cur_d = reg_wdata;

    if (strb.wr_tail) begin
      tail_d = reg_wdata;
      idle_d = 1'b0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= CTRL_RST;
      srst_q   <= 1'b0;
      halted_q <= 1'b1;
      idle_q   <= 1'b0;
      pend_q   <= '0;
      cur_q    <= '0;
      tail_q   <= '0;
      start_q  <= 1'b0;
    end else begin
      ctrl_q   <= ctrl_d;
      srst_q   <= srst_d;
      halted_q <= halted_d;
      idle_q   <= idle_d;
      pend_q   <= pend_d;
      cur_q    <= cur_d;
      tail_q   <= tail_d;
      start_q  <= start_d;
    end
  end

  // read mux
  always_comb begin
    reg_rdata = '0;
    unique case (rd_sel)
      SEL_CTRL: begin
        reg_rdata            = ctrl_q;
        reg_rdata[TMODE_BIT] = 1'b1;
        reg_rdata[SRST_BIT]  = srst_q;
      end
      SEL_STAT: begin
        reg_rdata[TMR_LO +: TMR_W] = tmr_val;
        reg_rdata[CNT_LO +: CNT_W] = cnt_val;
        reg_rdata[IRQ_LO +: IRQ_N] = pend_q;
        reg_rdata[1]               = idle_q;
        reg_rdata[0]               = halted_q;
      end
      SEL_CUR:  reg_rdata = cur_q;
      SEL_TAIL: reg_rdata = tail_q;
      default:  reg_rdata = '0;
    endcase
  end

  assign irq        = |(pend_q & ctrl_q[IRQ_LO +: IRQ_N]);
  assign eng_run    = ctrl_q[RUN_BIT];
  assign eng_reset  = srst_q;
  assign eng_halted = halted_q;
  assign eng_idle   = idle_q;
  assign eng_start  = start_q;
  assign cur_desc   = cur_q;
  assign tail_desc  = tail_q;
endmodule

// File: rtl/dma_chan_csr_chk.sv
module dma_chan_csr_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic              reg_rd_en,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic              eng_run,
  input logic              eng_reset,
  input logic              eng_halted,
  input logic              eng_idle,
  input logic              eng_start
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic is_ctrl, is_stat, is_cur, is_tail, unmapped;

  assign word     = reg_addr[ADDR_W-1:2];
  assign is_ctrl  = (word == WORD_W'(0));
  assign is_stat  = (word == WORD_W'(1));
  assign is_cur   = (word == WORD_W'(2));
  assign is_tail  = (word == WORD_W'(4));
  assign unmapped = !(is_ctrl || is_stat || is_cur || is_tail);

  AST_TAILMODE_READS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en && is_ctrl |-> reg_rdata[1]);  // R2

  AST_RUN_WRITE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en && is_ctrl && reg_wdata[0] && !reg_wdata[2] && !eng_reset
    |=> !eng_halted && !eng_idle && eng_run);  // R3

  AST_SRST_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en && is_ctrl && reg_wdata[2] |=> eng_halted && eng_reset && !eng_run);  // R4

  AST_SRST_CLEARED_BY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en && is_ctrl && !reg_wr_en |=> !eng_reset);  // R4

  AST_SRST_BLOCKS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en && is_ctrl && eng_reset && eng_halted |=> eng_halted);  // R4

  AST_STATUS_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en && is_stat |-> reg_rdata[0] == eng_halted && reg_rdata[1] == eng_idle
                              && reg_rdata[15:14] == 2'b00 && reg_rdata[11:2] == '0);  // R9

  AST_TAIL_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en && is_tail |=> eng_start && !eng_idle);  // R10

  AST_START_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> $past(reg_wr_en && is_tail));  // R10

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en && unmapped |-> reg_rdata == '0);  // R11
endmodule

bind dma_chan_csr dma_chan_csr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr_en  (reg_wr_en),
  .reg_rd_en  (reg_rd_en),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .eng_run    (eng_run),
  .eng_reset  (eng_reset),
  .eng_halted (eng_halted),
  .eng_idle   (eng_idle),
  .eng_start  (eng_start)
);

// File: tb/tb_dma_chan_csr.sv
`timescale 1ns/1ps
module tb_dma_chan_csr;
  localparam int ADDR_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic cmpl_pulse = 1'b0, tmr_tick = 1'b0, idle_req = 1'b0;
  logic irq, eng_run, eng_reset, eng_halted, eng_idle, eng_start;
  logic [31:0] cur_desc, tail_desc;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dma_chan_csr #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cmpl_pulse(cmpl_pulse), .tmr_tick(tmr_tick), .idle_req(idle_req),
    .irq(irq), .eng_run(eng_run), .eng_reset(eng_reset), .eng_halted(eng_halted),
    .eng_idle(eng_idle), .eng_start(eng_start), .cur_desc(cur_desc), .tail_desc(tail_desc)
  );

  // ---------------- reference model ----------------
  logic [31:0] m_ctrl, m_cur, m_tail;
  logic        m_rst, m_halt, m_idle, m_start;
  logic [1:0]  m_pend;
  int          m_cnt, m_tmr;

  function automatic logic [31:0] m_read(input logic [ADDR_W-1:0] a);
    case (int'(a[ADDR_W-1:2]))
      0: return {m_ctrl[31:3], m_rst, 1'b1, m_ctrl[0]};
      1: return {m_tmr[7:0], m_cnt[7:0], 2'b00, m_pend, 10'd0, m_idle, m_halt};
      2: return m_cur;
      4: return m_tail;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 32'h0001_0000; m_rst = 0; m_halt = 1; m_idle = 0; m_pend = 0;
      m_cnt = 1; m_tmr = 0; m_cur = 0; m_tail = 0; m_start = 0;
    end else begin
      int w, thr, dly;
      bit expd, ioc;
      w    = int'(reg_addr[ADDR_W-1:2]);
      thr  = int'(m_ctrl[23:16]);
      dly  = int'(m_ctrl[31:24]);
      expd = 0; ioc = 0;
      m_start = reg_wr_en && w == 4;
      // delay timer
      if (cmpl_pulse && dly != 0) m_tmr = dly;
      else if (tmr_tick && m_tmr != 0) begin
        m_tmr--;
        if (m_tmr == 0) expd = 1;
      end
      // threshold counter
      if (cmpl_pulse) begin
        m_cnt = (m_cnt + 255) % 256;
        if (m_cnt == 0) begin ioc = 1; m_cnt = thr; end
      end else if (expd) m_cnt = thr;
      // pending bits: clear first, then set wins
      if (reg_wr_en && w == 1) m_pend = m_pend & ~reg_wdata[13:12];
      if (ioc)  m_pend[0] = 1;
      if (expd) m_pend[1] = 1;
      if (idle_req) m_idle = 1;
      // control
      if (reg_wr_en && w == 0) begin
        if (reg_wdata[2]) begin
          m_ctrl = 32'h0001_0000; m_rst = 1; m_halt = 1; m_idle = 0;
          m_pend = 0; m_tmr = 0; m_cnt = 1;
        end else begin
          m_ctrl = reg_wdata & 32'hFFFF_FFF9;
          m_cnt  = int'(reg_wdata[23:16]);
          if (reg_wdata[0] && !m_rst) begin m_halt = 0; m_idle = 0; end
        end
      end else if (reg_rd_en && w == 0) m_rst = 0;
      if (reg_wr_en && w == 2) m_cur = reg_wdata;
      if (reg_wr_en && w == 4) begin m_tail = reg_wdata; m_idle = 0; end
    end
  end

  // ---------------- per-cycle output comparison ----------------
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [7:0] exp_o, act_o;
      exp_o = {|(m_pend & m_ctrl[13:12]), m_ctrl[0], m_rst, m_halt, m_idle, m_start, 2'b00};
      act_o = {irq, eng_run, eng_reset, eng_halted, eng_idle, eng_start, 2'b00};
      n_chk++;
      if (act_o !== exp_o || cur_desc !== m_cur || tail_desc !== m_tail) begin
        n_fail++;
        $display("FAIL R3/R4/R8/R10/R11 outputs {irq,run,rst,halt,idle,start}: act %b exp %b cur %h/%h tail %h/%h",
                 act_o[7:2], exp_o[7:2], cur_desc, m_cur, tail_desc, m_tail);
      end
    end
  end

  // ---------------- driver tasks (called at a negedge) ----------------
  task automatic step(input logic c, input logic t);
    cmpl_pulse = c; tmr_tick = t;
    @(negedge clk);
    cmpl_pulse = 0; tmr_tick = 0;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    reg_wr_en = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 0;
  endtask

  task automatic rd_lit(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string tag);
    reg_rd_en = 1; reg_addr = a;
    #1;
    n_chk++;
    if (reg_rdata !== e) begin
      n_fail++;
      $display("FAIL %s read @%h: act %h exp %h", tag, a, reg_rdata, e);
    end
    @(negedge clk);
    reg_rd_en = 0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input string tag);
    rd_lit(a, m_read(a), tag);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd_lit(6'h00, 32'h0001_0002, "R1");
    rd_lit(6'h04, 32'h0001_0001, "R1");
    rd_lit(6'h08, 32'h0, "R1");
    rd_lit(6'h10, 32'h0, "R1");

    // R2 / R3: threshold 3, both enables, run; bit1 written 0
    wr(6'h00, 32'h0003_3001);
    rd_lit(6'h00, 32'h0003_3003, "R2");
    rd_lit(6'h04, 32'h0003_0000, "R3");

    // R5: threshold counting without delay
    step(1, 0); rd_lit(6'h04, 32'h0002_0000, "R5");
    step(1, 1); step(1, 0);
    rd_lit(6'h04, 32'h0003_1000, "R5");
    n_chk++;
    if (irq !== 1'b1) begin n_fail++; $display("FAIL R8 irq act %b exp 1", irq); end

    // R8: disable IOC enable, irq drops, pending stays
    wr(6'h00, 32'h0003_2001);
    n_chk++;
    if (irq !== 1'b0) begin n_fail++; $display("FAIL R8 irq act %b exp 0", irq); end
    rd(6'h04, "R8");

    // R7: W1C, zeros keep, set beats clear
    wr(6'h04, 32'h0000_2000); rd_lit(6'h04, 32'h0003_1000, "R7");
    wr(6'h04, 32'h0000_1000); rd_lit(6'h04, 32'h0003_0000, "R7");
    step(1, 0); step(1, 0);
    reg_wr_en = 1; reg_addr = 6'h04; reg_wdata = 32'h0000_1000; cmpl_pulse = 1;
    @(negedge clk); reg_wr_en = 0; cmpl_pulse = 0;
    rd_lit(6'h04, 32'h0003_1000, "R7");
    wr(6'h04, 32'h0000_3000);

    // R6: delay 4, threshold 2; restart, expiry, counter reload
    wr(6'h00, 32'h0402_3001);
    step(1, 0); rd_lit(6'h04, 32'h0401_0000, "R6");
    step(0, 1); step(0, 1); rd_lit(6'h04, 32'h0201_0000, "R9");
    step(1, 1);                                  // restart beats tick
    rd_lit(6'h04, 32'h0402_1000, "R6");
    repeat (3) step(0, 1);
    rd_lit(6'h04, 32'h0102_1000, "R6");
    step(0, 1);
    rd_lit(6'h04, 32'h0002_3000, "R6");
    wr(6'h04, 32'h0000_3000);
    // zero delay: completion leaves a running timer alone
    step(1, 0);
    wr(6'h00, 32'h0005_3001);
    step(0, 1); step(1, 0);
    rd_lit(6'h04, 32'h0304_0000, "R6");

    // R5: control write beats same-cycle completion
    reg_wr_en = 1; reg_addr = 6'h00; reg_wdata = 32'h0007_3001; cmpl_pulse = 1;
    @(negedge clk); reg_wr_en = 0; cmpl_pulse = 0;
    rd(6'h04, "R5");

    // R10: tail write, idle request
    idle_req = 1; @(negedge clk); idle_req = 0;
    rd(6'h04, "R10");
    wr(6'h10, 32'hCAFE_0040);
    rd_lit(6'h10, 32'hCAFE_0040, "R10");
    idle_req = 1; reg_wr_en = 1; reg_addr = 6'h10; reg_wdata = 32'hCAFE_0080;
    @(negedge clk); idle_req = 0; reg_wr_en = 0;
    rd(6'h04, "R10");

    // R11: current pointer, unmapped words
    wr(6'h08, 32'h1234_5678);
    rd_lit(6'h08, 32'h1234_5678, "R11");
    wr(6'h0C, 32'hFFFF_FFFF); wr(6'h14, 32'hFFFF_FFFF); wr(6'h2C, 32'hFFFF_FFFF);
    rd_lit(6'h0C, 32'h0, "R11");
    rd_lit(6'h14, 32'h0, "R11");
    rd(6'h00, "R11"); rd(6'h04, "R11"); rd(6'h08, "R11"); rd(6'h10, "R11");

    // R4: soft reset, sticky bit, run blocked, cleared by first read
    step(1, 0);
    wr(6'h00, 32'hFFFF_FFFD);
    rd_lit(6'h04, 32'h0001_0001, "R4");
    wr(6'h00, 32'h0002_0001);
    rd_lit(6'h04, 32'h0002_0001, "R4");
    rd_lit(6'h00, 32'h0002_0007, "R4");
    rd_lit(6'h00, 32'h0002_0003, "R4");
    wr(6'h00, 32'h0002_0001);
    rd_lit(6'h04, 32'h0002_0000, "R3");

    // pseudo-random mix against the model
    wr(6'h00, 32'h0304_3001);
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cmpl_pulse = lfsr[0] & lfsr[3];
      tmr_tick   = lfsr[1];
      idle_req   = lfsr[7] & lfsr[8] & lfsr[9];
      if (lfsr[4] & lfsr[5]) begin
        reg_wr_en = 1; reg_addr = 6'h04; reg_wdata = {18'd0, lfsr[11:10], 12'd0};
      end else if (lfsr[6] & lfsr[2] & lfsr[11]) begin
        reg_wr_en = 1; reg_addr = 6'h10; reg_wdata = {16'd0, lfsr};
      end
      reg_rd_en = 1; reg_addr = reg_wr_en ? reg_addr : 6'h04;
      #1;
      n_chk++;
      if (reg_rdata !== m_read(reg_addr)) begin
        n_fail++;
        $display("FAIL R5/R6/R7/R9 mix read @%h: act %h exp %h", reg_addr, reg_rdata, m_read(reg_addr));
      end
      @(negedge clk);
      cmpl_pulse = 0; tmr_tick = 0; idle_req = 0; reg_wr_en = 0; reg_rd_en = 0;
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule